// File: doc/BRIEF.md
# Through-Parity Datapath Checker

This block sits between a media access controller and its physical-layer interface and guards three byte-wide paths with odd parity. Bytes received from the physical layer are checked, and so are bytes the MAC hands over for transmission. The transmit bytes go on to the physical layer with parity computed again inside the block, so a bad parity bit on the MAC side can never reach the line.

Each of the two checked inputs has its own enable bit in a small mode register. A master reset pulse clears both bits. A receive-side error counts as a code violation. When it lands inside a PDU, the block also pulses a strip request, a format-error indication and a lost-count increment. A transmit-side error that lands while the transmitter is acknowledged pulses an abort and a void-frame request. Either kind of error sets its own sticky status bit, which stays set until software writes one to that bit to clear it.

The transmit path is a valid/ready stream and passes straight through in the same cycle: valid and data travel forward and ready travels back, with no storage in between. A byte is taken, and checked, only in a cycle where both valid and ready are high. The receive path carries only a valid signal, because the line cannot be stalled.

Top module: `tpar_checker`

## Requirements
- R1: `prq_par` is always the odd parity of `prq_data` (so `prq_data` together with `prq_par` holds an odd number of ones), whatever the value of `mrq_par`.
- R2: `prq_valid` equals `mrq_valid`, `prq_data` equals `mrq_data`, and `mrq_ready` equals `prq_ready`, all in the same cycle.
- R3: A receive beat with `pi_valid` high and bad parity (an even number of ones in `pi_data` plus `pi_par`), while mode bit 0 is set, causes a one-cycle `code_viol` pulse in the next cycle and sets `sts[0]`.
- R4: If that receive error also has `pi_in_pdu` high, `pdu_strip`, `fmt_err` and `lost_inc` each pulse for one cycle together with `code_viol`. If `pi_in_pdu` is low, all three stay low.
- R5: While mode bit 0 is clear, receive parity errors cause no pulse and leave `sts[0]` unchanged.
- R6: A transmit handshake (`mrq_valid` and `prq_ready` both high) with bad parity on `mrq_data` plus `mrq_par`, while mode bit 1 is set and `tx_ack` is high, pulses `tx_abort` and `void_req` in the next cycle and sets `sts[1]`.
- R7: The same error with `tx_ack` low sets `sts[1]` but leaves `tx_abort` and `void_req` low.
- R8: While mode bit 1 is clear, and in any cycle without a handshake, transmit parity is not checked: no pulse, and `sts[1]` does not change.
- R9: Status bits are sticky. A one on `sts_clr[i]` clears `sts[i]` at the next edge, but a new error in the same cycle wins and keeps the bit set.
- R10: `mode_wr` loads `mode_wdata` into `mode_en` at the next edge. `master_rst` clears `mode_en` to zero and takes priority over a write in the same cycle.
- R11: After `rst_n` is low, `mode_en`, `sts` and every pulse output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the enable bits |
| mode_wdata | input | 2 | New enable bits: bit 0 receive, bit 1 transmit |
| master_rst | input | 1 | Clears both enable bits |
| mode_en | output | 2 | Current enable bits |
| pi_valid | input | 1 | Receive byte valid |
| pi_data | input | DATA_W | Receive byte |
| pi_par | input | 1 | Receive parity bit |
| pi_in_pdu | input | 1 | Receive byte lies inside a token or frame |
| mrq_valid | input | 1 | MAC transmit byte valid |
| mrq_ready | output | 1 | MAC transmit byte accepted |
| mrq_data | input | DATA_W | MAC transmit byte |
| mrq_par | input | 1 | MAC transmit parity bit |
| tx_ack | input | 1 | Transmitter currently acknowledged |
| prq_valid | output | 1 | Line transmit byte valid |
| prq_ready | input | 1 | Line side can take a byte |
| prq_data | output | DATA_W | Line transmit byte |
| prq_par | output | 1 | Regenerated odd parity |
| code_viol | output | 1 | Receive parity code-violation pulse |
| pdu_strip | output | 1 | Strip-current-PDU pulse |
| fmt_err | output | 1 | Format-error pulse |
| lost_inc | output | 1 | Lost-count increment pulse |
| tx_abort | output | 1 | Abort-transmission pulse |
| void_req | output | 1 | Void-frame request pulse |
| sts_clr | input | 2 | Write-one-to-clear for the status bits |
| sts | output | 2 | Sticky status: bit 0 receive error, bit 1 transmit error |

## Verification
Random receive bytes with good and bad parity, with the PDU flag set and clear, separate a plain code violation from the full strip reaction, and they also show that a disabled interface has no effect. Transmit beats are varied over valid, ready and acknowledge, so the tests tell a handshake apart from a stalled beat and an abort apart from a status-only error. A bad parity bit on MAC bytes shows that line parity is regenerated and not copied. Directed cycles place a clear against a new error in the same cycle, and a master reset against a mode write, to check both priorities.

// File: rtl/tpar_pkg.sv
package tpar_pkg;
  localparam int SRC_RX  = 0;
  localparam int SRC_TX  = 1;
  localparam int NUM_SRC = 2;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/tpar_mode_reg.sv
module tpar_mode_reg
  import tpar_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     master_rst,
  input  logic     wr,
  input  src_vec_t wdata,
  output src_vec_t mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode <= '0;
    else if (master_rst) mode <= '0;
    else if (wr)         mode <= wdata;
  end

  assert_mreset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master_rst) |-> (mode == '0));
endmodule

// File: rtl/tpar_rx_check.sv
module tpar_rx_check #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  input  logic              in_pdu,
  output logic              err_set,
  output logic              code_viol,
  output logic              pdu_strip,
  output logic              fmt_err,
  output logic              lost_inc
);
  logic bad_par;
  assign bad_par = ~(^{data, par});
  assign err_set = valid & en & bad_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_viol <= 1'b0;
      pdu_strip <= 1'b0;
      fmt_err   <= 1'b0;
      lost_inc  <= 1'b0;
    end else begin
      code_viol <= err_set;
      pdu_strip <= err_set & in_pdu;
      fmt_err   <= err_set & in_pdu;
      lost_inc  <= err_set & in_pdu;
    end
  end

  assert_strip_only_on_viol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pdu_strip |-> code_viol);
  assert_viol_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_viol |-> $past(en & valid));
endmodule

// File: rtl/tpar_tx_path.sv
module tpar_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_par,
  input  logic              tx_ack,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par,
  output logic              err_set,
  output logic              tx_abort,
  output logic              void_req
);
  logic xfer;
  assign xfer      = in_valid & out_ready;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = in_data;
  assign out_par   = ~(^in_data);
  assign err_set   = xfer & en & ~(^{in_data, in_par});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_abort <= 1'b0;
      void_req <= 1'b0;
    end else begin
      tx_abort <= err_set & tx_ack;
      void_req <= err_set & tx_ack;
    end
  end

  assert_out_odd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (^{out_data, out_par}));
  assert_abort_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> $past(tx_ack & in_valid & out_ready));
endmodule

// File: rtl/tpar_status.sv
module tpar_status
  import tpar_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set,
  input  src_vec_t clr,
  output src_vec_t sts
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts[i] <= 1'b0;
      else if (set[i]) sts[i] <= 1'b1;
      else if (clr[i]) sts[i] <= 1'b0;
    end

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sts[i]) && !$past(clr[i])) |-> sts[i]);
  end
endmodule

// File: rtl/tpar_checker.sv
module tpar_checker
  import tpar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic              master_rst,
  output logic [1:0]        mode_en,
  input  logic              pi_valid,
  input  logic [DATA_W-1:0] pi_data,
  input  logic              pi_par,
  input  logic              pi_in_pdu,
  input  logic              mrq_valid,
  output logic              mrq_ready,
  input  logic [DATA_W-1:0] mrq_data,
  input  logic              mrq_par,
  input  logic              tx_ack,
  output logic              prq_valid,
  input  logic              prq_ready,
  output logic [DATA_W-1:0] prq_data,
  output logic              prq_par,
  output logic              code_viol,
  output logic              pdu_strip,
  output logic              fmt_err,
  output logic              lost_inc,
  output logic              tx_abort,
  output logic              void_req,
  input  logic [1:0]        sts_clr,
  output logic [1:0]        sts
);
  src_vec_t mode_q;
  src_vec_t err_set;

  tpar_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .master_rst(master_rst),
    .wr(mode_wr), .wdata(mode_wdata), .mode(mode_q)
  );

  tpar_rx_check #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(mode_q[SRC_RX]),
    .valid(pi_valid), .data(pi_data), .par(pi_par), .in_pdu(pi_in_pdu),
    .err_set(err_set[SRC_RX]), .code_viol(code_viol), .pdu_strip(pdu_strip),
    .fmt_err(fmt_err), .lost_inc(lost_inc)
  );

  tpar_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(mode_q[SRC_TX]),
    .in_valid(mrq_valid), .in_ready(mrq_ready), .in_data(mrq_data),
    .in_par(mrq_par), .tx_ack(tx_ack),
    .out_valid(prq_valid), .out_ready(prq_ready), .out_data(prq_data),
    .out_par(prq_par), .err_set(err_set[SRC_TX]),
    .tx_abort(tx_abort), .void_req(void_req)
  );

  tpar_status u_sts (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(sts_clr), .sts(sts)
  );

  assign mode_en = mode_q;

  assert_viol_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    code_viol |-> sts[SRC_RX]);
  assert_abort_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (sts[SRC_TX] && void_req));
endmodule

// File: tb/tb_tpar_checker.sv
module tb_tpar_checker;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 0, master_rst = 0;
  logic [1:0] mode_wdata = 0, mode_en, sts_clr = 0, sts;
  logic pi_valid = 0, pi_par = 0, pi_in_pdu = 0;
  logic [DW-1:0] pi_data = 0, mrq_data = 0, prq_data;
  logic mrq_valid = 0, mrq_ready, mrq_par = 0, tx_ack = 0;
  logic prq_valid, prq_ready = 0, prq_par;
  logic code_viol, pdu_strip, fmt_err, lost_inc, tx_abort, void_req;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] e_mode = 0, e_sts = 0;

  always #2.5 clk = ~clk;

  tpar_checker #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .master_rst(master_rst), .mode_en(mode_en), .pi_valid(pi_valid),
    .pi_data(pi_data), .pi_par(pi_par), .pi_in_pdu(pi_in_pdu),
    .mrq_valid(mrq_valid), .mrq_ready(mrq_ready), .mrq_data(mrq_data),
    .mrq_par(mrq_par), .tx_ack(tx_ack), .prq_valid(prq_valid),
    .prq_ready(prq_ready), .prq_data(prq_data), .prq_par(prq_par),
    .code_viol(code_viol), .pdu_strip(pdu_strip), .fmt_err(fmt_err),
    .lost_inc(lost_inc), .tx_abort(tx_abort), .void_req(void_req),
    .sts_clr(sts_clr), .sts(sts)
  );

  function automatic logic odd_of(input logic [DW-1:0] d);
    int n = 0;
    for (int i = 0; i < DW; i++) n += int'(d[i]);
    return (n % 2 == 0);
  endfunction

  function automatic logic is_bad(input logic [DW-1:0] d, input logic p);
    return p != odd_of(d);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    mode_wr = 0; master_rst = 0; mode_wdata = 0; sts_clr = 0;
    pi_valid = 0; pi_data = 0; pi_par = 0; pi_in_pdu = 0;
    mrq_valid = 0; mrq_data = 0; mrq_par = 0; tx_ack = 0; prq_ready = 0;
  endtask

  // Inputs are already driven after a falling edge; check and advance one cycle.
  task automatic cycle();
    logic rx_err, rx_strip, tx_err, tx_ab;
    logic [1:0] n_sts, n_mode;
    string rtag, ttag, stag;
    #1;
    chk("R2", "prq_valid", prq_valid, mrq_valid);
    chk("R2", "mrq_ready", mrq_ready, prq_ready);
    chk("R2", "prq_data", prq_data, mrq_data);
    chk("R1", "prq_par", prq_par, odd_of(mrq_data));
    rx_err   = pi_valid & e_mode[0] & is_bad(pi_data, pi_par);
    rx_strip = rx_err & pi_in_pdu;
    tx_err   = mrq_valid & prq_ready & e_mode[1] & is_bad(mrq_data, mrq_par);
    tx_ab    = tx_err & tx_ack;
    n_sts    = (e_sts & ~sts_clr) | {tx_err, rx_err};
    n_mode   = master_rst ? 2'b00 : (mode_wr ? mode_wdata : e_mode);
    rtag = e_mode[0] ? "R3" : "R5";
    ttag = !e_mode[1] || !(mrq_valid && prq_ready) ? "R8" : (tx_ack ? "R6" : "R7");
    stag = (sts_clr != 0) ? "R9" : "R3";
    @(posedge clk);
    #1;
    chk(rtag, "code_viol", code_viol, rx_err);
    chk("R4", "pdu_strip", pdu_strip, rx_strip);
    chk("R4", "fmt_err", fmt_err, rx_strip);
    chk("R4", "lost_inc", lost_inc, rx_strip);
    chk(ttag, "tx_abort", tx_abort, tx_ab);
    chk(ttag, "void_req", void_req, tx_ab);
    chk(stag, "sts[0]", sts[0], n_sts[0]);
    chk((sts_clr != 0) ? "R9" : ttag, "sts[1]", sts[1], n_sts[1]);
    chk("R10", "mode_en", mode_en, n_mode);
    e_sts = n_sts; e_mode = n_mode;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    idle();
    repeat (3) @(negedge clk);
    chk("R11", "mode_en", mode_en, 0);
    chk("R11", "sts", sts, 0);
    chk("R11", "pulses", {code_viol, pdu_strip, fmt_err, lost_inc, tx_abort, void_req}, 0);
    rst_n = 1;
    @(negedge clk);
    // disabled: bad parity everywhere has no effect
    pi_valid = 1; pi_data = 8'h01; pi_par = 1; pi_in_pdu = 1;
    mrq_valid = 1; prq_ready = 1; mrq_data = 8'h03; mrq_par = 0; tx_ack = 1; cycle();
    mode_wr = 1; mode_wdata = 2'b11; cycle();
    // rx error inside PDU, tx error with ack
    pi_valid = 1; pi_data = 8'h01; pi_par = 1; pi_in_pdu = 1;
    mrq_valid = 1; prq_ready = 1; mrq_data = 8'h00; mrq_par = 0; tx_ack = 1; cycle();
    cycle();
    // rx error outside PDU, tx error without ack
    sts_clr = 2'b11; pi_valid = 1; pi_data = 8'hFF; pi_par = 0;
    mrq_valid = 1; prq_ready = 1; mrq_data = 8'h0F; mrq_par = 0; tx_ack = 0; cycle();
    // stalled bad beat is not checked
    sts_clr = 2'b11; cycle();
    mrq_valid = 1; prq_ready = 0; mrq_data = 8'h00; mrq_par = 0; tx_ack = 1; cycle();
    // master reset against write
    master_rst = 1; mode_wr = 1; mode_wdata = 2'b11; cycle();
    mode_wr = 1; mode_wdata = 2'b01; cycle();
    for (int n = 0; n < 2000; n++) begin
      pi_valid   = ($urandom_range(0, 3) != 0);
      pi_data    = DW'($urandom);
      pi_par     = ($urandom_range(0, 3) == 0) ? ~odd_of(pi_data) : odd_of(pi_data);
      pi_in_pdu  = $urandom_range(0, 1) == 1;
      mrq_valid  = $urandom_range(0, 3) != 0;
      prq_ready  = $urandom_range(0, 3) != 0;
      mrq_data   = DW'($urandom);
      mrq_par    = ($urandom_range(0, 3) == 0) ? ~odd_of(mrq_data) : odd_of(mrq_data);
      tx_ack     = $urandom_range(0, 1) == 1;
      mode_wr    = $urandom_range(0, 15) == 0;
      mode_wdata = 2'($urandom);
      master_rst = $urandom_range(0, 40) == 0;
      sts_clr    = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      cycle();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule